// File: doc/BRIEF.md
# LIN Bus Stuck-Level Fault Monitor

This block watches a LIN transceiver's digital side for three stuck conditions. The first is a bus held dominant. The second is a local transmit-data line held dominant. The third is a bus that stays recessive while the node is driving dominant. For each condition it keeps a fault flag. The flags drive the transmitter enable and a termination selector. The selector depends on the operating mode: in active mode it picks a weak internal current source, and in off-line mode it leaves the termination floating. A sticky transmitter-off bit records that the transmitter was shut down because the bus stayed recessive.

A fault is declared only after its condition has held for a programmable number of consecutive clock cycles. It is withdrawn only after the recovery condition has held for a shorter programmable count. Every change of any fault flag can raise an interrupt request, gated by an enable. A read strobe from the register interface clears both the interrupt request and the transmitter-off bit.

Top module: `lin_fault_monitor`

## Requirements
- R1: The bus-dominant flag sets on the edge at which `rx_lvl` has been 0 (dominant) for DOM_CYCLES consecutive clock edges. A single recessive sample restarts the count.
- R2: While the bus-dominant flag is set and `offline` is 0, `term_sel` is 2'b01 (weak current source).
- R3: While the bus-dominant flag is set and `offline` is 1, `term_sel` is 2'b10 (floating). With no bus-dominant fault, `term_sel` is 2'b00 (normal switch) in either mode.
- R4: The transmit-dominant flag sets after `tx_data` has been 0 for DOM_CYCLES consecutive edges. While that flag is set, `tx_en` is 0.
- R5: The bus-recessive flag sets after `tx_data`=0 together with `rx_lvl`=1 has held for REC_CYCLES consecutive edges. While that flag is set, `tx_en` is 0.
- R6: `txoff_flag` becomes 1 on the same edge as the bus-recessive flag sets. It stays 1 while that fault lasts and afterwards, and clears only on an edge with `rd_clr`=1 once the fault is gone.
- R7: Each flag clears after RCV_CYCLES consecutive edges of its recovery condition:
  - bus-dominant: `rx_lvl`=1
  - transmit-dominant: `tx_data`=1
  - bus-recessive: `rx_lvl` equal to `tx_data`
  
  `tx_en` returns to 1 once neither the transmit-dominant nor the bus-recessive flag is set.
- R8: On any edge where a flag sets or clears while `irq_en`=1, `irq` becomes 1 on that same edge. With `irq_en`=0, flag changes leave `irq` at 0.
- R9: `rd_clr`=1 clears `irq`. If a flag change with `irq_en`=1 happens on the same edge, `irq` stays 1.
- R10: A synchronous reset (`rst_n`=0 at an edge) brings the outputs to their idle values: all flags 0, `txoff_flag` 0, `irq` 0, `tx_en` 1, `term_sel` 2'b00. It also zeroes every counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_lvl | input | 1 | Sampled bus level, 1 = recessive |
| tx_data | input | 1 | Local transmit data, 0 = dominant |
| offline | input | 1 | 1 = off-line mode, 0 = active mode |
| irq_en | input | 1 | Interrupt enable for fault changes |
| rd_clr | input | 1 | Register-read strobe, clears irq and txoff_flag |
| tx_en | output | 1 | Transmitter enable |
| term_sel | output | 2 | 00 normal switch, 01 weak source, 10 floating |
| txoff_flag | output | 1 | Sticky transmitter-off status |
| bus_dom_flt | output | 1 | Bus clamped dominant |
| txd_dom_flt | output | 1 | Transmit data clamped dominant |
| bus_rec_flt | output | 1 | Bus clamped recessive |
| irq | output | 1 | Interrupt request pending |

## Verification
The embedded properties assume that every input is synchronous to `clk` and holds its value across an edge. They also assume that `rd_clr` is the only source of falling interrupt and transmitter-off indications. The bench changes inputs only on the falling clock edge and holds each vector for a whole number of cycles, so detection and recovery counts are exact. It runs with short cycle counts so that every set, clear, glitch and reset case fits in a few hundred cycles.

// File: rtl/lin_fm_pkg.sv
// Package: shared types for the LIN fault monitor.
// Assumes: nothing beyond the two-bit termination encoding used at the top.
package lin_fm_pkg;

    typedef enum logic [1:0] {
        TERM_NORMAL = 2'b00,
        TERM_WEAK   = 2'b01,
        TERM_FLOAT  = 2'b10
    } term_e;

    localparam int unsigned FLT_BUS_DOM = 0;
    localparam int unsigned FLT_TXD_DOM = 1;
    localparam int unsigned FLT_BUS_REC = 2;
    localparam int unsigned FLT_COUNT   = 3;

endpackage

// File: rtl/lin_stuck_det.sv
// Module: lin_stuck_det
// Generic fault qualifier. A flag sets after set_cond has held for
// SET_CYCLES consecutive edges, and clears after clr_cond has held for
// CLR_CYCLES consecutive edges. One counter serves both directions.
// Assumes: both counts are at least 1, and inputs are synchronous to clk.
module lin_stuck_det #(
    parameter int unsigned SET_CYCLES = 16,
    parameter int unsigned CLR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_cond,
    input  logic clr_cond,
    output logic flag,
    output logic set_evt,
    output logic chg_evt
);
    localparam int unsigned MAXN = (SET_CYCLES > CLR_CYCLES) ? SET_CYCLES : CLR_CYCLES;
    localparam int unsigned CW   = (MAXN > 1) ? $clog2(MAXN) : 1;
    localparam logic [CW-1:0] SET_LIM = CW'(SET_CYCLES - 1);
    localparam logic [CW-1:0] CLR_LIM = CW'(CLR_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          clr_evt;

    // Decide whether this edge completes a set or clear window.
    always_comb begin
        set_evt = !flag && set_cond && (cnt == SET_LIM);
        clr_evt =  flag && clr_cond && (cnt == CLR_LIM);
        chg_evt = set_evt || clr_evt;
    end

    // Count consecutive qualifying cycles and toggle the flag at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (chg_evt) begin
            cnt  <= '0;
            flag <= !flag;
        end else if ((!flag && set_cond) || (flag && clr_cond)) begin
            cnt  <= cnt + 1'b1;
        end else begin
            cnt  <= '0;
        end
    end

    // A flag may only rise after its set condition was present (R1, R4, R5).
    assert_set_needs_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(flag)) |-> $past(set_cond));

    // A flag may only fall after its recovery condition was present.
    assert_clear_needs_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(flag)) |-> $past(clr_cond));

endmodule

// File: rtl/lin_term_ctrl.sv
// Module: lin_term_ctrl
// Maps fault flags to the transmitter enable and the termination select.
// Assumes: flags come from registered detectors.
module lin_term_ctrl
    import lin_fm_pkg::*;
(
    input  logic  bus_dom,
    input  logic  txd_dom,
    input  logic  bus_rec,
    input  logic  offline,
    output logic  tx_en,
    output term_e term
);
    // Choose the termination source and gate the transmitter.
    always_comb begin
        tx_en = !(txd_dom || bus_rec);
        if (!bus_dom)     term = TERM_NORMAL;
        else if (offline) term = TERM_FLOAT;
        else              term = TERM_WEAK;
    end
endmodule

// File: rtl/lin_fm_irq.sv
// Module: lin_fm_irq
// Holds the interrupt-pending flag and the sticky transmitter-off bit.
// Assumes: chg is one bit per fault, each high for the edge its flag toggles.
module lin_fm_irq #(
    parameter int unsigned NFLT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFLT-1:0] chg,
    input  logic            rec_set,
    input  logic            rec_flt,
    input  logic            irq_en,
    input  logic            rd_clr,
    output logic            irq,
    output logic            txoff
);
    // Set wins over clear for both sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq   <= 1'b0;
            txoff <= 1'b0;
        end else begin
            irq   <= (irq_en && (|chg)) || (irq && !rd_clr);
            txoff <= rec_set || rec_flt || (txoff && !rd_clr);
        end
    end

    assert_irq_fall_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(irq)) |-> $past(rd_clr));

    assert_txoff_fall_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(txoff)) |-> ($past(rd_clr) && !$past(rec_flt)));
endmodule

// File: rtl/lin_fault_monitor.sv
// Module: lin_fault_monitor (top)
// Three stuck-level detectors feed termination/transmit control and an
// interrupt block. Default counts assume a 1 MHz clock (10 ms dominant).
// Assumes: rx_lvl is already synchronised to clk.
module lin_fault_monitor #(
    parameter int unsigned DOM_CYCLES = 10000,
    parameter int unsigned REC_CYCLES = 1000,
    parameter int unsigned RCV_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_lvl,
    input  logic       tx_data,
    input  logic       offline,
    input  logic       irq_en,
    input  logic       rd_clr,
    output logic       tx_en,
    output logic [1:0] term_sel,
    output logic       txoff_flag,
    output logic       bus_dom_flt,
    output logic       txd_dom_flt,
    output logic       bus_rec_flt,
    output logic       irq
);
    import lin_fm_pkg::*;

    logic [FLT_COUNT-1:0] set_c, clr_c, flt, set_e, chg_e;
    term_e                term_w;

    // Per-fault set and recovery conditions.
    always_comb begin
        set_c[FLT_BUS_DOM] = !rx_lvl;
        clr_c[FLT_BUS_DOM] =  rx_lvl;
        set_c[FLT_TXD_DOM] = !tx_data;
        clr_c[FLT_TXD_DOM] =  tx_data;
        set_c[FLT_BUS_REC] = !tx_data && rx_lvl;
        clr_c[FLT_BUS_REC] = (rx_lvl == tx_data);
    end

    generate
        for (genvar g = 0; g < FLT_COUNT; g++) begin : g_det
            localparam int unsigned SETN = (g == FLT_BUS_REC) ? REC_CYCLES : DOM_CYCLES;
            lin_stuck_det #(
                .SET_CYCLES(SETN),
                .CLR_CYCLES(RCV_CYCLES)
            ) i_det (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_cond(set_c[g]),
                .clr_cond(clr_c[g]),
                .flag    (flt[g]),
                .set_evt (set_e[g]),
                .chg_evt (chg_e[g])
            );
        end
    endgenerate

    lin_term_ctrl i_term (
        .bus_dom(flt[FLT_BUS_DOM]),
        .txd_dom(flt[FLT_TXD_DOM]),
        .bus_rec(flt[FLT_BUS_REC]),
        .offline(offline),
        .tx_en  (tx_en),
        .term   (term_w)
    );

    lin_fm_irq #(.NFLT(FLT_COUNT)) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .chg    (chg_e),
        .rec_set(set_e[FLT_BUS_REC]),
        .rec_flt(flt[FLT_BUS_REC]),
        .irq_en (irq_en),
        .rd_clr (rd_clr),
        .irq    (irq),
        .txoff  (txoff_flag)
    );

    // Drive the outputs from the internal flags.
    always_comb begin
        term_sel    = term_w;
        bus_dom_flt = flt[FLT_BUS_DOM];
        txd_dom_flt = flt[FLT_TXD_DOM];
        bus_rec_flt = flt[FLT_BUS_REC];
    end

    assert_irq_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(irq_en) && (flt != $past(flt))) |-> irq);

    assert_txoff_with_rec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rec_flt) |-> txoff_flag);

    assert_term_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(term_sel));

    assert_tx_off_after_rec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rec_flt) |-> !tx_en);

endmodule

// File: tb/test_lin_fault_monitor.sv
module test_lin_fault_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int DOM = 5;
    localparam int REC = 4;
    localparam int RCV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_lvl = 1'b1, tx_data = 1'b1, offline = 1'b0, irq_en = 1'b0, rd_clr = 1'b0;
    logic tx_en, txoff_flag, bus_dom_flt, txd_dom_flt, bus_rec_flt, irq;
    logic [1:0] term_sel;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_fault_monitor #(.DOM_CYCLES(DOM), .REC_CYCLES(REC), .RCV_CYCLES(RCV)) i_lin_fault_monitor (
        .clk(clk), .rst_n(rst_n), .rx_lvl(rx_lvl), .tx_data(tx_data), .offline(offline),
        .irq_en(irq_en), .rd_clr(rd_clr), .tx_en(tx_en), .term_sel(term_sel),
        .txoff_flag(txoff_flag), .bus_dom_flt(bus_dom_flt), .txd_dom_flt(txd_dom_flt),
        .bus_rec_flt(bus_rec_flt), .irq(irq)
    );

    // Vector fields: rx, txd, off, en, clr, hold[3:0] | txen, term[1:0], txoff, irq, flags{rec,txd,bus}
    localparam int NV = 14;
    localparam logic [16:0] VEC [NV] = '{
        {5'b11010, 4'd3, 1'b1, 2'b00, 1'b0, 1'b0, 3'b000}, // idle
        {5'b01010, 4'd4, 1'b1, 2'b00, 1'b0, 1'b0, 3'b000}, // R1 count not reached
        {5'b01010, 4'd1, 1'b1, 2'b01, 1'b0, 1'b1, 3'b001}, // R1 R2 R8 set, weak
        {5'b01111, 4'd1, 1'b1, 2'b10, 1'b0, 1'b0, 3'b001}, // R3 float, R9 clear
        {5'b11110, 4'd2, 1'b1, 2'b10, 1'b0, 1'b0, 3'b001}, // R7 recovery not done
        {5'b11110, 4'd1, 1'b1, 2'b00, 1'b0, 1'b1, 3'b000}, // R7 R3 cleared
        {5'b10011, 4'd3, 1'b1, 2'b00, 1'b0, 1'b0, 3'b000}, // R5 counting
        {5'b10010, 4'd1, 1'b0, 2'b00, 1'b1, 1'b1, 3'b100}, // R5 R6 rec set
        {5'b10010, 4'd1, 1'b0, 2'b00, 1'b1, 1'b1, 3'b110}, // R4 txd set
        {5'b11011, 4'd2, 1'b0, 2'b00, 1'b1, 1'b0, 3'b110}, // R7 pending, R6 held
        {5'b11010, 4'd1, 1'b1, 2'b00, 1'b1, 1'b1, 3'b000}, // R7 both clear, R6 sticky
        {5'b11011, 4'd1, 1'b1, 2'b00, 1'b0, 1'b0, 3'b000}, // R6 read clears
        {5'b01000, 4'd5, 1'b1, 2'b01, 1'b0, 1'b0, 3'b001}, // R8 irq disabled
        {5'b11000, 4'd3, 1'b1, 2'b00, 1'b0, 1'b0, 3'b000}  // R7 clear, no irq
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Assumes the caller is at a falling edge.
    task automatic step(input logic [4:0] in, input int n);
        {rx_lvl, tx_data, offline, irq_en, rd_clr} = in;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_all(input string req, input logic [7:0] exp);
        chk(req, {24'd0, tx_en, term_sel, txoff_flag, irq, bus_rec_flt, txd_dom_flt, bus_dom_flt}, {24'd0, exp});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_all("R10 reset state", 8'b1_00_0_0_000);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][16:12], int'(VEC[i][11:8]));
            chk_all($sformatf("vector %0d (R1-R9 table)", i), VEC[i][7:0]);
        end
        // R1 glitch restarts the dominant count
        step(5'b01010, 4);
        step(5'b11010, 1);
        step(5'b01010, 4);
        chk("R1 glitch restart", {31'd0, bus_dom_flt}, 32'd0);
        step(5'b01010, 1);
        chk("R1 set after full window", {31'd0, bus_dom_flt}, 32'd1);
        chk("R8 irq on set", {31'd0, irq}, 32'd1);
        // R9 clear and set on same edge: set wins
        step(5'b11011, 2);
        chk("R9 read clears irq", {31'd0, irq}, 32'd0);
        step(5'b11011, 1);
        chk("R9 set beats clear", {31'd0, irq}, 32'd1);
        chk("R7 bus dominant cleared", {31'd0, bus_dom_flt}, 32'd0);
        // R10 reset in the middle of faults
        step(5'b00010, 6);
        chk("R4 txd fault before reset", {31'd0, txd_dom_flt}, 32'd1);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_all("R10 reset clears faults", 8'b1_00_0_0_000);
        rst_n = 1'b1;
        step(5'b11010, 1);
        chk_all("R10 idle after reset", 8'b1_00_0_0_000);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule